// File: doc/BRIEF.md
# Cross-Domain Control Register with Three Output Modes

This block is a single 8-bit control register that software writes on the bus clock and whose bits drive control inputs of logic clocked by a second, unrelated target clock. Every output bit is independent, so each one can be wired to any control input of the target logic: a counter reset, an enable, a start strobe.

A static two-bit mode input chooses how a written value shows up on the outputs. In direct mode the outputs are the bus-clock register itself. In level mode the register goes through a two-flop synchronizer on the target clock, so the outputs are clean target-domain levels. In pulse mode each bit written as 1 appears as a pulse exactly one target-clock cycle long. The register then clears itself. A toggle handshake returns an acknowledge to the bus side, and a new pulse request is taken only after that acknowledge has arrived.

Writes use a valid/ready port. A write takes effect only on a bus-clock edge where both `wr_valid` and `wr_ready` are high. In direct and level modes `wr_ready` stays high. In pulse mode `wr_ready` drops from the edge that takes a non-zero word until the acknowledge comes back. A write offered while `wr_ready` is low is not taken. A master that needs it must hold it until `wr_ready` returns.

Top module: `ctl_xdom_reg`

## Requirements
- R1: When both resets (active high, one per clock domain) are released, `ctl_out` is 0 and `wr_ready` is 1.
- R2: The mode encoding is 2'b00 direct, 2'b01 level, 2'b10 pulse. The value 2'b11 behaves exactly like direct.
- R3: In direct mode, `ctl_out` equals the last word taken, starting immediately after the bus-clock edge that takes it.
- R4: In level mode, a new word reaches `ctl_out` on the 2nd or 3rd target-clock rising edge after the bus edge that takes it. All bits change together, and the value then holds.
- R5: In pulse mode, each bit written as 1 makes that output bit high for exactly one target-clock cycle. The pulse starts on the 3rd or 4th target-clock edge after the bus edge that takes the word.
- R6: In pulse mode, bits written as 0 produce no pulse. An all-zero word produces no pulse and leaves `wr_ready` high.
- R7: In pulse mode, `wr_ready` is low from the edge that takes a non-zero word until its acknowledge returns. A word offered while `wr_ready` is low has no effect and produces no extra pulse.
- R8: In pulse mode, no taken request is lost. `wr_ready` returns high within 12 target-clock cycles, after which the next word can be taken.
- R9: Output bits act independently. In every mode, any pattern of bits is carried bit for bit.
- R10: A word is taken only when `wr_valid` and `wr_ready` are both high. In direct and level modes, `wr_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus (write-side) clock |
| bus_rst | input | 1 | Active-high reset for the bus-clock domain |
| tgt_clk | input | 1 | Target-logic clock |
| tgt_rst | input | 1 | Active-high reset for the target-clock domain |
| mode | input | 2 | Static output mode: 00 direct, 01 level, 10 pulse, 11 direct |
| wr_valid | input | 1 | Write request |
| wr_data | input | 8 | Word to write |
| wr_ready | output | 1 | Write can be taken this edge |
| ctl_out | output | 8 | Control outputs toward the target logic |

## Verification
A wrong register bit shows up on `ctl_out` in direct mode on the very next bus edge. In level mode it shows up two or three target edges later, as a wrong or split value. In pulse mode, a lost or duplicated toggle appears at the ports in one of three ways:
- a missing pulse,
- a second pulse,
- `wr_ready` stuck low, which the bench sees within about a dozen target cycles of the write.

A broken self-clear shows up as a wrong pulse count on a later write to the same bit.

// File: rtl/ctl_xdom_pkg.sv
package ctl_xdom_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_LEVEL  = 2'b01,
    MODE_PULSE  = 2'b10,
    MODE_ALT    = 2'b11
  } ctl_mode_e;

  localparam int unsigned CTL_WIDTH_DEF  = 8;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
endpackage

// File: rtl/ctl_bit_sync.sv
module ctl_bit_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned CHAIN_W = W * STAGES;

  generate
    if (STAGES == 1) begin : g_single
      logic [W-1:0] flop_q;
      always_ff @(posedge clk or posedge rst) begin
        if (rst) flop_q <= '0;
        else     flop_q <= d;
      end
      assign q = flop_q;
    end else begin : g_chain
      logic [CHAIN_W-1:0] chain_q;
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN_W-W-1:0], d};
      end
      assign q = chain_q[CHAIN_W-1 -: W];
    end
  endgenerate
endmodule

// File: rtl/ctl_bus_port.sv
module ctl_bus_port #(
  parameter int unsigned W = 8
) (
  input  logic         bus_clk,
  input  logic         bus_rst,
  input  logic         pulse_mode,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         ack_tgl_sync,
  output logic [W-1:0] ctl_q,
  output logic         req_tgl
);
  logic pending;
  logic take;

  assign pending  = req_tgl ^ ack_tgl_sync;
  assign wr_ready = !(pulse_mode && pending);
  assign take     = wr_valid && wr_ready;

  always_ff @(posedge bus_clk or posedge bus_rst) begin
    if (bus_rst) begin
      ctl_q   <= '0;
      req_tgl <= 1'b0;
    end else if (pulse_mode) begin
      if (take && (wr_data != '0)) begin
        ctl_q   <= wr_data;
        req_tgl <= ~req_tgl;
      end else if (!pending) begin
        ctl_q   <= '0;
      end
    end else if (take) begin
      ctl_q <= wr_data;
    end
  end
endmodule

// File: rtl/ctl_pulse_gen.sv
module ctl_pulse_gen #(
  parameter int unsigned W = 8
) (
  input  logic         tgt_clk,
  input  logic         tgt_rst,
  input  logic         req_tgl_sync,
  input  logic [W-1:0] req_bits,
  output logic [W-1:0] pulse_q,
  output logic         ack_tgl
);
  logic fresh;
  assign fresh = req_tgl_sync ^ ack_tgl;

  always_ff @(posedge tgt_clk or posedge tgt_rst) begin
    if (tgt_rst) begin
      ack_tgl <= 1'b0;
      pulse_q <= '0;
    end else begin
      ack_tgl <= req_tgl_sync;
      pulse_q <= fresh ? req_bits : '0;
    end
  end
endmodule

// File: rtl/ctl_xdom_reg.sv
module ctl_xdom_reg
  import ctl_xdom_pkg::*;
#(
  parameter int unsigned WIDTH      = CTL_WIDTH_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic             bus_clk,
  input  logic             bus_rst,
  input  logic             tgt_clk,
  input  logic             tgt_rst,
  input  logic [1:0]       mode,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  output logic [WIDTH-1:0] ctl_out
);
  ctl_mode_e        mode_e;
  logic [WIDTH-1:0] bus_q;
  logic [WIDTH-1:0] lvl_q;
  logic [WIDTH-1:0] pulse_q;
  logic             req_tgl;
  logic             req_tgl_sync;
  logic             ack_tgl;
  logic             ack_tgl_sync;

  assign mode_e = ctl_mode_e'(mode);

  ctl_bus_port #(.W(WIDTH)) u_bus (
    .bus_clk      (bus_clk),
    .bus_rst      (bus_rst),
    .pulse_mode   (mode_e == MODE_PULSE),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .wr_ready     (wr_ready),
    .ack_tgl_sync (ack_tgl_sync),
    .ctl_q        (bus_q),
    .req_tgl      (req_tgl)
  );

  ctl_bit_sync #(.W(WIDTH), .STAGES(SYNC_DEPTH)) u_lvl_sync (
    .clk (tgt_clk),
    .rst (tgt_rst),
    .d   (bus_q),
    .q   (lvl_q)
  );

  ctl_bit_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_req_sync (
    .clk (tgt_clk),
    .rst (tgt_rst),
    .d   (req_tgl),
    .q   (req_tgl_sync)
  );

  ctl_pulse_gen #(.W(WIDTH)) u_pulse (
    .tgt_clk      (tgt_clk),
    .tgt_rst      (tgt_rst),
    .req_tgl_sync (req_tgl_sync),
    .req_bits     (bus_q),
    .pulse_q      (pulse_q),
    .ack_tgl      (ack_tgl)
  );

  ctl_bit_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk (bus_clk),
    .rst (bus_rst),
    .d   (ack_tgl),
    .q   (ack_tgl_sync)
  );

  always_comb begin
    unique case (mode_e)
      MODE_LEVEL: ctl_out = lvl_q;
      MODE_PULSE: ctl_out = pulse_q;
      default:    ctl_out = bus_q;
    endcase
  end
endmodule

// File: rtl/ctl_xdom_reg_chk.sv
module ctl_xdom_reg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             bus_clk,
  input logic             bus_rst,
  input logic             tgt_clk,
  input logic             tgt_rst,
  input logic [1:0]       mode,
  input logic             wr_valid,
  input logic [WIDTH-1:0] wr_data,
  input logic             wr_ready,
  input logic [WIDTH-1:0] ctl_out,
  input logic [WIDTH-1:0] bus_q
);
  // R3: direct mode presents the taken word on the next bus edge
  a_r3_direct_follows: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (mode == 2'b00 && wr_valid && wr_ready) |=> (ctl_out == $past(wr_data)));

  // R10: ready never drops outside pulse mode
  a_r10_ready_high: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (mode != 2'b10) |-> wr_ready);

  // R7: a taken non-zero pulse word makes the port busy
  a_r7_busy_after_take: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (mode == 2'b10 && wr_valid && wr_ready && wr_data != '0) |=> !wr_ready);

  // R7: a word offered while busy does not load the register
  a_r7_busy_ignored: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (mode == 2'b10 && wr_valid && !wr_ready) |=> (bus_q == $past(bus_q) || bus_q == '0));

  // R6: an all-zero pulse word leaves the port ready
  a_r6_zero_word: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (mode == 2'b10 && wr_valid && wr_ready && wr_data == '0) |=> wr_ready);

  // R5: a pulse lasts a single target cycle
  a_r5_one_cycle: assert property (@(posedge tgt_clk) disable iff (tgt_rst)
    (mode == 2'b10 && ctl_out != '0) |=> (ctl_out == '0));
endmodule

bind ctl_xdom_reg ctl_xdom_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .bus_clk  (bus_clk),
  .bus_rst  (bus_rst),
  .tgt_clk  (tgt_clk),
  .tgt_rst  (tgt_rst),
  .mode     (mode),
  .wr_valid (wr_valid),
  .wr_data  (wr_data),
  .wr_ready (wr_ready),
  .ctl_out  (ctl_out),
  .bus_q    (bus_q)
);

// File: tb/ctl_xdom_reg_bench.sv
module ctl_xdom_reg_bench;
  localparam int W = 8;

  logic         bus_clk = 1'b0;
  logic         tgt_clk = 1'b0;
  logic         bus_rst = 1'b1;
  logic         tgt_rst = 1'b1;
  logic [1:0]   mode    = 2'b00;
  logic         wr_valid = 1'b0;
  logic [W-1:0] wr_data  = '0;
  logic         wr_ready;
  logic [W-1:0] ctl_out;

  int total = 0;
  int bad   = 0;
  int tcnt  = 0;

  ctl_xdom_reg u_ctl_xdom_reg (
    .bus_clk  (bus_clk),
    .bus_rst  (bus_rst),
    .tgt_clk  (tgt_clk),
    .tgt_rst  (tgt_rst),
    .mode     (mode),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .ctl_out  (ctl_out)
  );

  // 125 MHz bus clock; target clock 36 ns, offset so edges never meet
  always #4 bus_clk = ~bus_clk;
  initial begin
    #3;
    forever #18 tgt_clk = ~tgt_clk;
  end
  always @(posedge tgt_clk) tcnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    bus_rst  = 1'b1;
    tgt_rst  = 1'b1;
    wr_valid = 1'b0;
    mode     = m;
    repeat (3) @(posedge tgt_clk);
    @(negedge bus_clk);
    bus_rst = 1'b0;
    tgt_rst = 1'b0;
    repeat (2) @(negedge tgt_clk);
    check(ctl_out === '0, "R1 out after reset", int'(ctl_out), 0);
    check(wr_ready === 1'b1, "R1 ready after reset", int'(wr_ready), 1);
  endtask

  // offers a word for one bus edge; returns whether it was taken
  task automatic offer(input logic [W-1:0] d, output bit taken);
    @(negedge bus_clk);
    wr_valid = 1'b1;
    wr_data  = d;
    taken    = wr_ready;
    @(posedge bus_clk);
    wr_valid <= 1'b0;
  endtask

  task automatic level_case(input logic [W-1:0] v, input logic [W-1:0] prev);
    bit taken;
    int t0;
    int lat;
    lat = 0;
    offer(v, taken);
    t0 = tcnt;
    check(taken, "R10 level ready", int'(taken), 1);
    for (int k = 0; k < 6; k++) begin
      @(posedge tgt_clk);
      #1;
      if (ctl_out === v) begin
        lat = tcnt - t0;
        break;
      end
      if (ctl_out !== prev) check(1'b0, "R4 split value", int'(ctl_out), int'(prev));
    end
    check(lat >= 2 && lat <= 3, "R4 level latency", lat, 2);
    repeat (3) @(posedge tgt_clk);
    #1;
    check(ctl_out === v, "R4 level holds", int'(ctl_out), int'(v));
  endtask

  task automatic pulse_case(input logic [W-1:0] v, input bit extra);
    bit taken;
    int t0;
    int first;
    int cnt [W];
    for (int b = 0; b < W; b++) cnt[b] = 0;
    first = 0;
    offer(v, taken);
    t0 = tcnt;
    check(taken, "R8 pulse accepted", int'(taken), 1);
    fork
      begin
        for (int k = 0; k < 12; k++) begin
          @(posedge tgt_clk);
          #1;
          if (ctl_out !== '0 && first == 0) first = tcnt - t0;
          for (int b = 0; b < W; b++) if (ctl_out[b] === 1'b1) cnt[b]++;
        end
      end
      begin
        if (extra) begin
          @(negedge bus_clk);
          wr_valid = 1'b1;
          wr_data  = '1;
          check(wr_ready === 1'b0, "R7 busy while pending", int'(wr_ready), 0);
          @(posedge bus_clk);
          wr_valid <= 1'b0;
        end
      end
    join
    for (int b = 0; b < W; b++) begin
      if (v[b]) check(cnt[b] == 1, "R5 R9 one pulse per set bit", cnt[b], 1);
      else      check(cnt[b] == 0, "R6 R9 no pulse on clear bit", cnt[b], 0);
    end
    if (v != '0) check(first >= 3 && first <= 4, "R5 pulse latency", first, 3);
    @(negedge bus_clk);
    check(wr_ready === 1'b1, "R8 ready returns", int'(wr_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit taken;
    logic [W-1:0] prev;

    // direct mode: full sweep of word values
    do_reset(2'b00);
    for (int v = 0; v < 256; v++) begin
      offer(W'(v), taken);
      #1;
      check(ctl_out === W'(v), "R3 R9 direct value", int'(ctl_out), v);
      check(wr_ready === 1'b1, "R10 direct ready", int'(wr_ready), 1);
    end
    // R10: valid low leaves output alone
    @(negedge bus_clk);
    wr_data = 8'h5A;
    repeat (3) @(negedge bus_clk);
    check(ctl_out === 8'hFF, "R10 no take without valid", int'(ctl_out), 8'hFF);

    // R2: code 11 behaves as direct
    do_reset(2'b11);
    for (int v = 1; v < 256; v += 51) begin
      offer(W'(v), taken);
      #1;
      check(ctl_out === W'(v), "R2 alt code acts direct", int'(ctl_out), v);
    end

    // level mode sweep
    do_reset(2'b01);
    prev = '0;
    for (int k = 0; k < 32; k++) begin
      logic [W-1:0] v;
      v = W'((k * 37 + 5) & 255);
      if (v == prev) v = ~v;
      level_case(v, prev);
      prev = v;
    end

    // pulse mode: every single bit, mixtures, zero word, busy writes
    do_reset(2'b10);
    for (int b = 0; b < W; b++) pulse_case(W'(1 << b), 1'b0);
    pulse_case(8'hA5, 1'b0);
    pulse_case(8'h5A, 1'b1);
    pulse_case(8'hFF, 1'b1);
    pulse_case(8'h00, 1'b0);
    for (int b = 0; b < W; b++) pulse_case(W'(1 << b), 1'b1);
    pulse_case(8'h81, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule